// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vector

This block raises a periodic interrupt request. Software programs an 8-bit reload count and two divide-by-512 selects into a 16-bit control register. A down-counter advances on each enabled tick of a timer clock-enable input. That input is used either directly or through a 512-step prescaler. When the period runs out, the counter reloads itself and the request is raised.

The request stays raised until an acknowledge strobe arrives. During that acknowledge the block places a programmable 8-bit vector on its vector output. It also presents the vector table address, which is a base value plus four times the vector number. A second 8-bit register holds the vector.

Both registers sit behind one synchronous read/write port. The port only honours accesses that carry the supervisor qualifier. The second divide select only controls an external watchdog, and the block simply exports it.

Top module: `pit_vec_timer`

## Requirements
- R1: In the control register (acc_sel=0), bits 15 to 10 always read as zero, and writing ones to them leaves every readable bit unchanged.
- R2: Control bit 8 selects the timer prescale. With bit 8 = 1, one period is count × 512 tick cycles. With bit 8 = 0, one period is count tick cycles.
- R3: Control bit 9 is driven on wd_prescale and has no effect on the period of the timer.
- R4: With a count value (control bits 7:0) of zero, irq never rises, however many ticks arrive.
- R5: Reset is synchronous on rst_n low. Each reset cycle loads bits 9 and 8 with the inverse of mode_clk, so the value sampled in the last reset cycle is the one kept. All other register bits reset to zero, and irq resets low.
- R6: After a write of nonzero count N with no prescale, irq rises after exactly N tick cycles. The counter then reloads, so the following expiries come every N ticks.
- R7: A supervisor write of the control register with a nonzero count restarts the counter from that count and clears the 512-step prescaler.
- R8: irq stays high until a cycle with iack high. Expiries that happen while irq is already high are not queued, so after the acknowledge irq stays low until the next expiry.
- R9: When iack is high while irq is high, vec_valid is 1 and vec_data equals the vector register (acc_sel=1, bits 7:0). Otherwise both are zero.
- R10: vec_addr equals vbase plus four times the vector register value.
- R11: An access with sup low changes no register on a write and returns zero on a read.
- R12: If an expiry and an acknowledge fall in the same cycle, irq is still high in the following cycle.
- R13: Both registers can be read back at any time, including while the timer is running, and they return the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_clk | input | 1 | Mode pin; its inverse is loaded into both prescale selects during reset |
| tmr_tick | input | 1 | Timer clock enable, one tick per high cycle |
| acc_sel | input | 1 | Register select: 0 control, 1 vector |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sup | input | 1 | Supervisor qualifier for the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| iack | input | 1 | Interrupt acknowledge strobe |
| vbase | input | 32 | Vector base value |
| irq | output | 1 | Periodic interrupt request |
| vec_valid | output | 1 | Acknowledge is being answered |
| vec_data | output | 8 | Vector driven during an answered acknowledge |
| vec_addr | output | 32 | Vector table address |
| wd_prescale | output | 1 | Watchdog divide-by-512 select |

## Verification
The one collision the request logic must settle is an expiry and an acknowledge landing on the same clock edge. The bench provokes it by programming a period of three and letting the first request stay pending. It then raises the acknowledge exactly three ticks after the first rise. The judgement is that the request is still high afterwards and drops only on a later acknowledge. A companion case places the acknowledge one tick after an absorbed expiry, and there the request must go low and rise again only at the next expiry.

// File: rtl/pit_vec_timer.sv
module pit_vec_timer #(
  parameter int CW      = 8,
  parameter int VW      = 8,
  parameter int AW      = 32,
  parameter int PRE_DIV = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_clk,
  input  logic          tmr_tick,
  input  logic          acc_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          sup,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic          iack,
  input  logic [AW-1:0] vbase,
  output logic          irq,
  output logic          vec_valid,
  output logic [VW-1:0] vec_data,
  output logic [AW-1:0] vec_addr,
  output logic          wd_prescale
);
  localparam int PW      = $clog2(PRE_DIV);
  localparam int PTP_BIT = CW;
  localparam int SWP_BIT = CW + 1;

  logic [CW-1:0] count_q, cnt_q;
  logic [VW-1:0] vec_q;
  logic [PW-1:0] pre_q;
  logic          ptp_q, swp_q, irq_q;

  wire wr_tmr   = wr_en & sup & ~acc_sel;
  wire wr_vec   = wr_en & sup &  acc_sel;
  wire run      = (count_q != '0);
  wire pre_wrap = (pre_q == PW'(PRE_DIV - 1));
  wire tick_en  = tmr_tick & run & (~ptp_q | pre_wrap);
  wire expire   = tick_en & (cnt_q == CW'(1)) & ~wr_tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
      vec_q   <= '0;
      irq_q   <= 1'b0;
      ptp_q   <= ~mode_clk;
      swp_q   <= ~mode_clk;
    end else begin
      if (wr_tmr) begin
        count_q <= wdata[CW-1:0];
        cnt_q   <= wdata[CW-1:0];
        ptp_q   <= wdata[PTP_BIT];
        swp_q   <= wdata[SWP_BIT];
        pre_q   <= '0;
      end else begin
        if (tmr_tick && run) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
        if (tick_en) cnt_q <= (cnt_q <= CW'(1)) ? count_q : cnt_q - 1'b1;
      end
      if (wr_vec) vec_q <= wdata[VW-1:0];
      irq_q <= expire | (irq_q & ~iack);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && sup) begin
      if (acc_sel) rdata[VW-1:0] = vec_q;
      else begin
        rdata[CW-1:0]  = count_q;
        rdata[PTP_BIT] = ptp_q;
        rdata[SWP_BIT] = swp_q;
      end
    end
  end

  assign irq         = irq_q;
  assign wd_prescale = swp_q;
  assign vec_valid   = iack & irq_q;
  assign vec_data    = vec_valid ? vec_q : '0;
  assign vec_addr    = vbase + (AW'(vec_q) << 2);

  AST_RST_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ptp_q == ~$past(mode_clk)) && (swp_q == ~$past(mode_clk)) && !irq_q); // R5
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |=> !$rose(irq)); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !iack) |=> irq); // R8
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && iack && !expire) |=> !irq); // R8
  AST_ACK_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && expire) |=> irq); // R12
  AST_USER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sup) |=> $stable(count_q) && $stable(vec_q) && $stable(ptp_q) && $stable(swp_q)); // R11
  AST_USER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sup) |-> (rdata == '0)); // R11
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr == vbase + (AW'(vec_data) << 2))); // R10
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_data == '0)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_sel) |-> (rdata[15:10] == 6'd0)); // R1
endmodule

// File: tb/pit_vec_timer_bench.sv
module pit_vec_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, mode_clk = 0, tmr_tick = 0;
  logic        acc_sel = 0, wr_en = 0, rd_en = 0, sup = 0, iack = 0;
  logic [15:0] wdata = 0, rdata;
  logic [31:0] vbase = 0, vec_addr;
  logic        irq, vec_valid, wd_prescale;
  logic [7:0]  vec_data;
  int n_chk = 0, n_bad = 0;
  logic [15:0] sh_tmr;
  logic [7:0]  sh_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_vec_timer u_pit_vec_timer (
    .clk(clk), .rst_n(rst_n), .mode_clk(mode_clk), .tmr_tick(tmr_tick),
    .acc_sel(acc_sel), .wr_en(wr_en), .rd_en(rd_en), .sup(sup),
    .wdata(wdata), .rdata(rdata), .iack(iack), .vbase(vbase), .irq(irq),
    .vec_valid(vec_valid), .vec_data(vec_data), .vec_addr(vec_addr),
    .wd_prescale(wd_prescale));

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [7:0] v);
    return b + {22'd0, v, 2'b00};
  endfunction

  function automatic logic [15:0] tmr_view(input logic [15:0] d);
    return d & 16'h03FF;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d, input logic s);
    acc_sel = a; wdata = d; sup = s; wr_en = 1;
    step;
    wr_en = 0; sup = 0;
    if (s) begin
      if (a) sh_vec = d[7:0]; else sh_tmr = tmr_view(d);
    end
  endtask

  task automatic rd(input logic a, input logic s, output logic [15:0] v);
    acc_sel = a; sup = s; rd_en = 1;
    #1 v = rdata;
    rd_en = 0; sup = 0;
  endtask

  task automatic wait_irq(input int max, output int n);
    n = 0;
    while (!irq && n < max) begin step; n++; end
  endtask

  task automatic ack;
    iack = 1; step; iack = 0;
  endtask

  task automatic quiet;
    wr(0, 16'h0000, 1);
    ack;
  endtask

  task automatic do_reset(input logic m);
    rst_n = 0; mode_clk = m;
    repeat (3) step;
    mode_clk = ~m;
    rst_n = 1;
    sh_tmr = m ? 16'h0000 : 16'h0300;
    sh_vec = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'd2024));
    @(negedge clk);

    // R5 reset with mode pin high
    do_reset(1);
    rd(0, 1, v); chk(v == 16'h0000, "R5 ctrl after reset mode=1", v, 16'h0000);
    chk(irq == 0 && wd_prescale == 0, "R5 irq/wd after reset", {irq, wd_prescale}, 0);
    do_reset(0);
    rd(0, 1, v); chk(v == 16'h0300, "R5 ctrl after reset mode=0", v, 16'h0300);
    rd(1, 1, v); chk(v == 16'h0000, "R5 vector after reset", v, 0);
    chk(wd_prescale == 1, "R5 wd_prescale", wd_prescale, 1);

    // R1 reserved bits
    wr(0, 16'hFC00, 1);
    rd(0, 1, v); chk(v == 16'h0000, "R1 reserved write", v, 0);
    wr(0, 16'hFFFF, 1); wr(0, 16'hFF00, 1);
    rd(0, 1, v); chk(v == 16'h0300, "R1 reserved read zero", v, 16'h0300);

    // R11 non-supervisor access
    wr(0, 16'h0155, 0); wr(1, 16'h00AA, 0);
    rd(0, 1, v); chk(v == 16'h0300, "R11 user write ctrl ignored", v, 16'h0300);
    rd(1, 1, v); chk(v == 16'h0000, "R11 user write vec ignored", v, 0);
    rd(0, 0, v); chk(v == 16'h0000, "R11 user read zero", v, 0);

    // R4 zero count
    wr(0, 16'h0000, 1);
    tmr_tick = 1;
    repeat (1500) step;
    chk(irq == 0, "R4 zero count idle", irq, 0);

    // R6 R9 R10 period, vector, address
    wr(1, 16'h0041, 1); vbase = 32'h0001_0000;
    wr(0, 16'h0005, 1);
    wait_irq(100, n); chk(n == 5, "R6 first period", n, 5);
    iack = 1; #1;
    chk(vec_valid == 1 && vec_data == 8'h41, "R9 vector on ack", vec_data, 8'h41);
    chk(vec_addr == exp_addr(vbase, 8'h41), "R10 vector address", vec_addr, exp_addr(vbase, 8'h41));
    step; iack = 0;
    chk(irq == 0, "R8 ack clears", irq, 0);
    wait_irq(100, n); chk(n + 1 == 5, "R6 reload period", n + 1, 5);
    rd(0, 1, v); chk(v == 16'h0005, "R13 read while running", v, 16'h0005);
    rd(1, 1, v); chk(v == 16'h0041, "R13 vector read", v, 16'h0041);
    iack = 0; #1;
    chk(vec_valid == 0 && vec_data == 0, "R9 no ack no vector", vec_data, 0);
    quiet;

    // R3 watchdog select no effect on period
    wr(0, 16'h0207, 1);
    chk(wd_prescale == 1, "R3 wd_prescale set", wd_prescale, 1);
    wait_irq(100, n); chk(n == 7, "R3 period unaffected", n, 7);
    quiet;
    chk(wd_prescale == 0, "R3 wd_prescale clear", wd_prescale, 0);

    // R2 prescaled period
    wr(0, 16'h0102, 1);
    wait_irq(3000, n); chk(n == 1024, "R2 prescaled period", n, 1024);
    quiet;

    // R7 restart count
    wr(0, 16'h000A, 1);
    repeat (6) step;
    wr(0, 16'h0004, 1);
    wait_irq(100, n); chk(n == 4, "R7 restart count", n, 4);
    quiet;
    // R7 prescaler cleared on write
    wr(0, 16'h0101, 1);
    repeat (300) step;
    chk(irq == 0, "R7 no early irq", irq, 0);
    wr(0, 16'h0101, 1);
    wait_irq(2000, n); chk(n == 512, "R7 prescaler restart", n, 512);
    quiet;

    // R8 expiry while pending not queued
    wr(0, 16'h0003, 1);
    wait_irq(100, n);
    repeat (4) step;
    chk(irq == 1, "R8 held without ack", irq, 1);
    ack;
    chk(irq == 0, "R8 pending expiry not queued", irq, 0);
    wait_irq(100, n); chk(n == 1, "R8 next expiry", n, 1);
    quiet;

    // R12 ack and expiry in same cycle
    wr(0, 16'h0003, 1);
    wait_irq(100, n);
    repeat (2) step;
    ack;
    chk(irq == 1, "R12 expiry wins over ack", irq, 1);
    ack;
    chk(irq == 0, "R12 later ack clears", irq, 0);
    quiet;

    // R6 random periods
    for (int i = 0; i < 8; i++) begin
      int c;
      c = 1 + int'($urandom % 30);
      wr(0, 16'(c), 1);
      wait_irq(200, n); chk(n == c, "R6 random period", n, c);
      quiet;
    end
    tmr_tick = 0;

    // R11 R13 R10 random register traffic
    for (int i = 0; i < 60; i++) begin
      logic [15:0] d;
      logic a, s;
      d = 16'($urandom); a = 1'($urandom); s = 1'($urandom);
      wr(a, d, s);
      rd(0, 1, v); chk(v == sh_tmr, "R13 random ctrl readback", v, sh_tmr);
      rd(1, 1, v); chk(v == {8'h00, sh_vec}, "R13 random vector readback", v, sh_vec);
      rd(a, 0, v); chk(v == 0, "R11 random user read", v, 0);
      vbase = $urandom; #1;
      chk(vec_addr == exp_addr(vbase, sh_vec), "R10 random address", vec_addr, exp_addr(vbase, sh_vec));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule